// File: doc/BRIEF.md
# Symbol-Wide Pseudorandom Pattern Generator over GF(8)

This block produces a 12-bit pseudorandom test pattern on every enabled clock. It is a shift register of four symbols, each a 3-bit element of the field GF(8) built on x^3 + x + 1. On each step the symbol leaving the last stage is scaled by a fixed field constant for every stage, and the product is added (XOR) into the symbol moving up from the stage below. Stage 0 simply takes its product. Because every scaling is by a constant, each multiplier reduces to a small fixed XOR matrix.

The four feedback constants are a parameter. The defaults give the characteristic polynomial x^4 + a·x^3 + a^6·x^2 + a^5, where a is the primitive field element. That polynomial is primitive over GF(8), so the register visits all 4095 non-zero 12-bit states before it repeats. A seed may be loaded at any time and takes priority over stepping. A zero seed would lock the register, so it is replaced by all ones. The state output is a plain registered bus that the consumer samples whenever it likes.

Top module: `glfsr_gf8`

## Requirements
- R1: A synchronous reset sets the state to all ones (12'hFFF); the first clock after reset shows 12'hFFF.
- R2: With `load` high and a non-zero `seed`, the state on the next clock equals `seed`.
- R3: With `load` high and `seed` equal to zero, the state on the next clock is 12'hFFF.
- R4: When `load` and `step` are both high, the load wins and the step has no effect.
- R5: Encoding: `state[3*i+k]` is the coefficient of a^k of stage i, with stage 0 in bits 2:0 and stage 3 in bits 11:9. On a step with the default constants (c0=a^5=3'b111, c1=0, c2=a^6=3'b101, c3=a=3'b010), stage 0 becomes c0·s3 and stage i becomes s(i-1) XOR ci·s3, using GF(8) products modulo x^3 + x + 1.
- R6: With neither `load` nor `step` high, the state holds.
- R7: After reset the state is never zero, under any mix of steps and loads.
- R8: From 12'hFFF the first two steps give 12'h47B and then 12'hB9D. The state returns to 12'hFFF after exactly 4095 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load `seed` into the register on this clock |
| seed | input | 12 | Seed pattern, same bit layout as `state` |
| step | input | 1 | Advance the register by one step |
| state | output | 12 | Current pattern (four 3-bit symbols) |

## Verification
The bound checker watches the local rules on every clock. It checks that reset yields all ones, that a load captures the seed or replaces a zero seed with all ones, that the state holds when idle, that a step always changes the state, and that the state never becomes zero. Whether a step computes the right GF(8) products, and whether the constants give a full-length cycle, cannot be judged from one cycle. The bench's table-based field model covers the first, clock by clock. A full 4095-step walk back to the seed covers the second.

// File: rtl/glfsr_pkg.sv
package glfsr_pkg;
  // Field symbol width and reduction polynomial (x^3 + x + 1, low bits)
  localparam int unsigned SYM_W      = 3;
  localparam logic [SYM_W-1:0] FIELD_POLY = 3'b011;
  localparam int unsigned STAGES     = 4;

  // Multiply a field element by the primitive element a
  function automatic logic [SYM_W-1:0] mul_alpha(input logic [SYM_W-1:0] v);
    logic [SYM_W-1:0] r;
    r = {v[SYM_W-2:0], 1'b0};
    if (v[SYM_W-1]) r = r ^ FIELD_POLY;
    return r;
  endfunction
endpackage

// File: rtl/gf_const_mul.sv
module gf_const_mul
  import glfsr_pkg::*;
#(
  parameter logic [SYM_W-1:0] COEF = '0
) (
  input  logic [SYM_W-1:0] din,
  output logic [SYM_W-1:0] dout
);
  // Column j of the constant matrix is COEF * a^j
  function automatic logic [SYM_W-1:0] column(input int unsigned j);
    logic [SYM_W-1:0] c;
    c = COEF;
    for (int unsigned t = 0; t < j; t++) c = mul_alpha(c);
    return c;
  endfunction

  always_comb begin
    dout = '0;
    for (int unsigned j = 0; j < SYM_W; j++) begin
      if (din[j]) dout = dout ^ column(j);
    end
  end
endmodule

// File: rtl/glfsr_cell.sv
module glfsr_cell
  import glfsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [SYM_W-1:0] seed_sym,
  input  logic [SYM_W-1:0] next_sym,
  output logic [SYM_W-1:0] sym
);
  always_ff @(posedge clk) begin
    if (rst)       sym <= '1;
    else if (load) sym <= seed_sym;
    else if (step) sym <= next_sym;
  end
endmodule

// File: rtl/glfsr_gf8.sv
module glfsr_gf8
  import glfsr_pkg::*;
#(
  // Stage i constant in bits [i*SYM_W +: SYM_W]; default a^5, 0, a^6, a
  parameter logic [STAGES*SYM_W-1:0] COEFS = 12'b010_101_000_111
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [STAGES*SYM_W-1:0] seed,
  input  logic                    step,
  output logic [STAGES*SYM_W-1:0] state
);
  localparam int unsigned N = STAGES * SYM_W;

  logic [N-1:0]     eff_seed;
  logic [N-1:0]     prod;
  logic [N-1:0]     nxt;
  logic [SYM_W-1:0] fb;

  assign eff_seed = (seed == '0) ? '1 : seed;
  assign fb       = state[N-1 -: SYM_W];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    gf_const_mul #(.COEF(COEFS[i*SYM_W +: SYM_W])) u_mul (
      .din  (fb),
      .dout (prod[i*SYM_W +: SYM_W])
    );
    if (i == 0) begin : g_head
      assign nxt[SYM_W-1:0] = prod[SYM_W-1:0];
    end else begin : g_body
      assign nxt[i*SYM_W +: SYM_W] = prod[i*SYM_W +: SYM_W] ^ state[(i-1)*SYM_W +: SYM_W];
    end
    glfsr_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .step     (step),
      .seed_sym (eff_seed[i*SYM_W +: SYM_W]),
      .next_sym (nxt[i*SYM_W +: SYM_W]),
      .sym      (state[i*SYM_W +: SYM_W])
    );
  end
endmodule

// File: rtl/glfsr_gf8_chk.sv
module glfsr_gf8_chk #(
  parameter int unsigned N = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic [N-1:0] seed,
  input logic         step,
  input logic [N-1:0] state
);
  logic was_rst = 1'b0;
  logic live    = 1'b0;

  always_ff @(posedge clk) begin
    was_rst <= rst;
    live    <= !rst;
    if (was_rst && !rst) begin
      AST_RESET_ONES: assert (state == '1); // R1
    end
  end

  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst)
    live && $past(load) && ($past(seed) != '0) |-> state == $past(seed)); // R2

  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (rst)
    live && $past(load) && ($past(seed) == '0) |-> state == '1); // R3

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
    live && $past(step) && !$past(load) |-> state != $past(state)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    live && !$past(load) && !$past(step) |-> $stable(state)); // R6

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    live |-> state != '0); // R7
endmodule

bind glfsr_gf8 glfsr_gf8_chk #(.N(STAGES*SYM_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .load  (load),
  .seed  (seed),
  .step  (step),
  .state (state)
);

// File: tb/glfsr_gf8_test.sv
module glfsr_gf8_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [11:0] seed = '0;
  logic        step = 1'b0;
  logic [11:0] state;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int exp_t[7];
  int log_t[8];
  int coef[4] = '{7, 0, 5, 2};

  logic [11:0] model = 12'hFFF;
  bit          cmp_on = 1'b0;
  string       tag = "R6";

  always #2 clk = ~clk;

  glfsr_gf8 uut (
    .clk(clk), .rst(rst), .load(load), .seed(seed), .step(step), .state(state)
  );

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[(log_t[a] + log_t[b]) % 7];
  endfunction

  function automatic logic [11:0] advance(logic [11:0] s);
    logic [11:0] n;
    int top;
    top = int'(s[11:9]);
    n[2:0] = 3'(gmul(coef[0], top));
    for (int i = 1; i < 4; i++)
      n[3*i +: 3] = s[3*(i-1) +: 3] ^ 3'(gmul(coef[i], top));
    return n;
  endfunction

  task automatic chk(bit ok, string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: state=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model, updated on the same edge as the design
  always @(posedge clk) begin
    if (rst)       model <= 12'hFFF;
    else if (load) model <= (seed == '0) ? 12'hFFF : seed;
    else if (step) model <= advance(model);
  end

  always @(negedge clk) begin
    if (cmp_on) chk(state === model, tag, state, model);
  end

  task automatic cyc(bit l, logic [11:0] s, bit st, string t);
    load = l; seed = s; step = st; tag = t;
    @(negedge clk);
  endtask

  initial begin
    int v = 1;
    for (int i = 0; i < 7; i++) begin
      exp_t[i] = v;
      log_t[v] = i;
      v = v << 1;
      if ((v & 8) != 0) v = v ^ 11;
    end
  end

  initial begin
    int n;
    int zeros;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(state === 12'hFFF, "R1 reset", state, 12'hFFF);
    cmp_on = 1'b1;

    // R8 golden first steps, R5 step arithmetic
    cyc(0, 0, 1, "R5");
    chk(state === 12'h47B, "R8 first step", state, 12'h47B);
    cyc(0, 0, 1, "R5");
    chk(state === 12'hB9D, "R8 second step", state, 12'hB9D);

    // R6 hold
    cyc(0, 0, 0, "R6");
    chk(state === 12'hB9D, "R6 hold", state, 12'hB9D);
    cyc(0, 12'h123, 0, "R6");

    // R2 load, then steps from several seeds
    cyc(1, 12'h001, 0, "R2");
    chk(state === 12'h001, "R2 load", state, 12'h001);
    for (int k = 0; k < 10; k++) cyc(0, 0, 1, "R5");
    cyc(1, 12'hA5C, 0, "R2");
    chk(state === 12'hA5C, "R2 load", state, 12'hA5C);
    for (int k = 0; k < 10; k++) cyc(0, 0, k % 3 != 0, "R5");

    // R3 zero seed
    cyc(1, 12'h000, 0, "R3");
    chk(state === 12'hFFF, "R3 zero seed", state, 12'hFFF);

    // R4 load beats step
    cyc(1, 12'h800, 1, "R4");
    chk(state === 12'h800, "R4 load priority", state, 12'h800);
    cyc(1, 12'h000, 1, "R4");
    chk(state === 12'hFFF, "R4 zero seed with step", state, 12'hFFF);

    // R1 reset mid-run
    cyc(0, 0, 1, "R5");
    rst = 1'b1; step = 1'b1; tag = "R1";
    @(negedge clk);
    rst = 1'b0;
    chk(state === 12'hFFF, "R1 reset mid-run", state, 12'hFFF);

    // R8 full period, R7 never zero
    n = 0; zeros = 0;
    load = 0; step = 1; tag = "R8";
    do begin
      @(negedge clk);
      n++;
      if (state === 12'h000) zeros++;
    end while (state !== 12'hFFF && n < 5000);
    step = 0;
    chk(n == 4095, "R8 period", 12'(n), 12'(4095));
    chk(zeros == 0, "R7 never zero", 12'(zeros), 12'h000);

    cyc(0, 0, 0, "R6");
    cmp_on = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: state=%h expected=%h", state, 12'hFFF);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule